// File: doc/BRIEF.md
# Hazard-Aware Handshake Receiver Stage

This block is the receiving side of a pipeline handshake. A plain valid/ready link uses one backward bit. Here the stage also guards against read-after-write hazards. Each sender beat carries a valid bit, the index of the source register the sending stage reads, a destination index, a load-type flag and a data word. The stage answers with three backward signals:

- an availability bit that plays the part of ready;
- the index of the register it holds locked for a pending write;
- a flag that says whether that lock is in force.

A beat is taken only when the stage is available and the beat's source index does not match an active lock. A sender that is refused keeps its beat steady and waits.

The lock models a load in flight. An accepted load-type beat with a nonzero destination locks that destination. A separate result-ready strobe releases the lock. The strobe stands for the loaded value reaching the bypass point, so a dependent consumer that was held back may then proceed. Accepted beats go into a one-entry holding register. A simple valid/ready drain port empties it downstream. Register index 0 is hard-wired and never causes a stall.

Top module: `hazard_rx_stage`

## Requirements
- R1: While reset is asserted and in the first cycle after it, lock_act and dn_vld are 0 and avail is 1.
- R2: A beat is accepted in a cycle exactly when in_vld, avail and the absence of a lock collision all hold in that cycle.
- R3: A lock collision means lock_act is 1, in_src equals lock_idx and in_src is nonzero. A colliding beat is not accepted, and dn_vld stays 0 if the holding register was empty.
- R4: Source index 0 never collides. An accepted load-type beat with in_dst equal to 0 leaves the lock unchanged, and lock_idx is never 0 while lock_act is 1.
- R5: An accepted beat with in_is_load equal to 1 and a nonzero in_dst makes lock_act 1 and lock_idx equal to in_dst in the next cycle. This replaces any lock already held.
- R6: A cycle with wb_done equal to 1 makes lock_act 0 in the next cycle, unless a lock-setting beat is accepted in that same cycle, in which case the new lock stands.
- R7: A sender stalled on a collision is accepted in the first cycle in which lock_act reads 0, and its data appears on dn_data in the cycle after.
- R8: An accepted beat's in_data and in_src appear on dn_data and dn_src with dn_vld equal to 1 in the cycle after acceptance.
- R9: While dn_vld is 1 and dn_rdy is 0, the holding register keeps dn_vld, dn_data and dn_src unchanged, and avail is 0.
- R10: avail is 1 when the holding register is empty or dn_rdy is 1. With dn_rdy held at 1, one beat per cycle passes through back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_vld | input | 1 | Sender beat valid |
| in_src | input | IDX_W | Source register index read by the sender |
| in_dst | input | IDX_W | Destination index written by a load-type beat |
| in_is_load | input | 1 | Beat is load-type and locks its destination |
| in_data | input | DATA_W | Beat data word |
| avail | output | 1 | Stage can accept a beat (ready role) |
| lock_idx | output | IDX_W | Register index currently locked |
| lock_act | output | 1 | Lock is in force |
| wb_done | input | 1 | Result-ready strobe that releases the lock |
| dn_vld | output | 1 | Holding register holds a beat |
| dn_src | output | IDX_W | Source index of the held beat |
| dn_data | output | DATA_W | Data of the held beat |
| dn_rdy | input | 1 | Downstream takes the held beat |

## Verification
The bench sets a lock on every nonzero index. For each one it offers the matching source, the neighbour index and index 0. A comparator that ignored the lock flag, or that let index 0 collide, would take or refuse the wrong beat. The bench holds a stalled sender across the release strobe and expects acceptance in exactly the first unlocked cycle. An off-by-one clear would show as a lost or delayed beat. It also raises the release strobe in the same cycle as a new lock-setting load, where a design that gave the clear priority would drop the new lock. Finally it stalls the drain port with a beat held. A design that overwrote the holding register or kept avail high would corrupt dn_data.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  typedef enum logic [1:0] {
    LK_KEEP  = 2'd0,
    LK_SET   = 2'd1,
    LK_CLEAR = 2'd2
  } lock_op_e;

  // A new lock wins over a release in the same cycle.
  function automatic lock_op_e pick_lock_op(input logic set_req, input logic clr_req);
    if (set_req)      return LK_SET;
    else if (clr_req) return LK_CLEAR;
    else              return LK_KEEP;
  endfunction

  // Occupancy of a one-entry holding register after one edge.
  function automatic logic next_occupancy(input logic take, input logic full, input logic drain);
    if (take)               return 1'b1;
    else if (full && drain) return 1'b0;
    else                    return full;
  endfunction

endpackage

// File: rtl/hzd_collide.sv
module hzd_collide #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             lock_on,
  input  logic [IDX_W-1:0] lock_at,
  input  logic [IDX_W-1:0] probe,
  output logic             hit
);
  logic [IDX_W-1:0] bit_eq;
  logic             probe_nz;

  for (genvar b = 0; b < IDX_W; b++) begin : g_eq
    assign bit_eq[b] = ~(lock_at[b] ^ probe[b]);
  end

  assign probe_nz = |probe;
  assign hit      = lock_on && (&bit_eq) && probe_nz;
endmodule

// File: rtl/hzd_lock_tracker.sv
module hzd_lock_tracker #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_req,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_req,
  output logic             lock_on,
  output logic [IDX_W-1:0] lock_at
);
  import hzd_pkg::*;

  lock_op_e op;
  logic     set_ok;

  assign set_ok = set_req && (|set_idx);
  assign op     = pick_lock_op(set_ok, clr_req);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lock_on <= 1'b0;
      lock_at <= '0;
    end else begin
      unique case (op)
        LK_SET: begin
          lock_on <= 1'b1;
          lock_at <= set_idx;
        end
        LK_CLEAR: lock_on <= 1'b0;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/hzd_hold_reg.sv
module hzd_hold_reg #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [IDX_W-1:0]  take_src,
  input  logic [DATA_W-1:0] take_data,
  input  logic              drain,
  output logic              full,
  output logic [IDX_W-1:0]  held_src,
  output logic [DATA_W-1:0] held_data
);
  import hzd_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      held_src  <= '0;
      held_data <= '0;
    end else begin
      full <= next_occupancy(take, full, drain);
      if (take) begin
        held_src  <= take_src;
        held_data <= take_data;
      end
    end
  end
endmodule

// File: rtl/hazard_rx_stage.sv
module hazard_rx_stage #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_vld,
  input  logic [IDX_W-1:0]  in_src,
  input  logic [IDX_W-1:0]  in_dst,
  input  logic              in_is_load,
  input  logic [DATA_W-1:0] in_data,
  output logic              avail,
  output logic [IDX_W-1:0]  lock_idx,
  output logic              lock_act,
  input  logic              wb_done,
  output logic              dn_vld,
  output logic [IDX_W-1:0]  dn_src,
  output logic [DATA_W-1:0] dn_data,
  input  logic              dn_rdy
);
  logic hold_full;
  logic hit_w;
  logic accept_w;
  logic drain_w;
  logic lock_set_w;

  assign avail      = !hold_full || dn_rdy;
  assign accept_w   = in_vld && avail && !hit_w;
  assign drain_w    = hold_full && dn_rdy;
  assign lock_set_w = accept_w && in_is_load;

  hzd_collide #(.IDX_W(IDX_W)) u_collide (
    .lock_on (lock_act),
    .lock_at (lock_idx),
    .probe   (in_src),
    .hit     (hit_w)
  );

  hzd_lock_tracker #(.IDX_W(IDX_W)) u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_req (lock_set_w),
    .set_idx (in_dst),
    .clr_req (wb_done),
    .lock_on (lock_act),
    .lock_at (lock_idx)
  );

  hzd_hold_reg #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (accept_w),
    .take_src  (in_src),
    .take_data (in_data),
    .drain     (drain_w),
    .full      (hold_full),
    .held_src  (dn_src),
    .held_data (dn_data)
  );

  assign dn_vld = hold_full;
endmodule

// File: rtl/hazard_rx_checker.sv
module hazard_rx_checker #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_vld,
  input logic [IDX_W-1:0]  in_src,
  input logic [IDX_W-1:0]  in_dst,
  input logic [DATA_W-1:0] in_data,
  input logic              avail,
  input logic [IDX_W-1:0]  lock_idx,
  input logic              lock_act,
  input logic              wb_done,
  input logic              dn_vld,
  input logic [IDX_W-1:0]  dn_src,
  input logic [DATA_W-1:0] dn_data,
  input logic              dn_rdy,
  input logic              accept_w,
  input logic              lock_set_w
);
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!lock_act && !dn_vld));

  assert_no_collide_take_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && lock_act && in_src == lock_idx && !dn_vld) |=> !dn_vld);

  assert_lock_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_act |-> (lock_idx != '0));

  assert_lock_from_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_act) |-> $past(lock_set_w));

  assert_lock_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_set_w && in_dst != '0) |=> (lock_act && lock_idx == $past(in_dst)));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_done && !(lock_set_w && in_dst != '0)) |=> !lock_act);

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> (dn_vld && dn_data == $past(in_data) && dn_src == $past(in_src)));

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_vld && !dn_rdy) |=> (dn_vld && $stable(dn_data) && $stable(dn_src)));

  assert_backpressure_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_vld && !dn_rdy) |-> !avail);

  assert_avail_when_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!dn_vld || dn_rdy) |-> avail);
endmodule

bind hazard_rx_stage hazard_rx_checker #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_vld     (in_vld),
  .in_src     (in_src),
  .in_dst     (in_dst),
  .in_data    (in_data),
  .avail      (avail),
  .lock_idx   (lock_idx),
  .lock_act   (lock_act),
  .wb_done    (wb_done),
  .dn_vld     (dn_vld),
  .dn_src     (dn_src),
  .dn_data    (dn_data),
  .dn_rdy     (dn_rdy),
  .accept_w   (accept_w),
  .lock_set_w (lock_set_w)
);

// File: tb/test_hazard_rx_stage.sv
module test_hazard_rx_stage;
  localparam int IDX_W  = 5;
  localparam int DATA_W = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic              rst_n;
  logic              in_vld, in_is_load, wb_done, dn_rdy;
  logic [IDX_W-1:0]  in_src, in_dst;
  logic [DATA_W-1:0] in_data;
  logic              avail, lock_act, dn_vld;
  logic [IDX_W-1:0]  lock_idx, dn_src;
  logic [DATA_W-1:0] dn_data;

  hazard_rx_stage #(.IDX_W(IDX_W), .DATA_W(DATA_W)) i_hazard_rx_stage (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_src(in_src), .in_dst(in_dst),
    .in_is_load(in_is_load), .in_data(in_data), .avail(avail), .lock_idx(lock_idx),
    .lock_act(lock_act), .wb_done(wb_done), .dn_vld(dn_vld), .dn_src(dn_src),
    .dn_data(dn_data), .dn_rdy(dn_rdy)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Bench-side expectation, built from the requirements.
  bit              m_full = 0;
  bit              m_lk   = 0;
  logic [IDX_W-1:0]  m_lki  = '0;
  logic [IDX_W-1:0]  m_src  = '0;
  logic [DATA_W-1:0] m_data = '0;

  function automatic bit m_avail();
    return !m_full || dn_rdy;
  endfunction

  function automatic bit m_hit();
    return m_lk && (m_lki == in_src) && (in_src != 0);
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drv(bit v, int s, int d, bit ld, logic [31:0] x, bit wb, bit rdy);
    in_vld = v; in_src = s[IDX_W-1:0]; in_dst = d[IDX_W-1:0];
    in_is_load = ld; in_data = x; wb_done = wb; dn_rdy = rdy;
  endtask

  task automatic step(string tag);
    bit f;
    #1 chk(tag, "avail", avail, m_avail());
    @(posedge clk);
    f = in_vld && m_avail() && !m_hit();
    if (f) begin
      m_full = 1; m_src = in_src; m_data = in_data;
    end else if (m_full && dn_rdy) begin
      m_full = 0;
    end
    if (f && in_is_load && in_dst != 0) begin
      m_lk = 1; m_lki = in_dst;
    end else if (wb_done) begin
      m_lk = 0;
    end
    @(negedge clk);
    chk(tag, "lock_act", lock_act, m_lk);
    if (m_lk) chk(tag, "lock_idx", lock_idx, m_lki);
    chk(tag, "dn_vld", dn_vld, m_full);
    if (m_full) begin
      chk(tag, "dn_data", dn_data, m_data);
      chk(tag, "dn_src", dn_src, m_src);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drv(0, 0, 0, 0, 32'h0, 0, 1);
    repeat (3) @(posedge clk);
    #1 chk("R1", "lock_act in reset", lock_act, 0);
    chk("R1", "dn_vld in reset", dn_vld, 0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R1");
    chk("R1", "avail after reset", avail, 1);

    // Lock r5, then sweep every source index past it.
    drv(1, 0, 5, 1, 32'hA5A5_0000, 0, 1);
    step("R5");
    chk("R5", "lock_idx after load", lock_idx, 5);
    for (int s = 0; s < 32; s++) begin
      drv(1, s, 0, 0, 32'h1000_0000 + s, 0, 1);
      step(s == 5 ? "R3" : (s == 0 ? "R4" : "R2"));
    end

    // Stalled consumer on r5, released by the strobe.
    drv(1, 5, 0, 0, 32'hDEAD_BEEF, 0, 1);
    step("R3"); step("R3");
    chk("R3", "no take under lock", dn_vld, 0);
    drv(1, 5, 0, 0, 32'hDEAD_BEEF, 1, 1);
    step("R6");
    chk("R6", "lock released", lock_act, 0);
    drv(1, 5, 0, 0, 32'hDEAD_BEEF, 0, 1);
    step("R7");
    chk("R7", "taken first unlocked cycle", dn_vld, 1);
    chk("R7", "taken data", dn_data, 32'hDEAD_BEEF);

    // Load to r0 locks nothing.
    drv(1, 3, 0, 1, 32'h0000_0033, 0, 1);
    step("R4");
    chk("R4", "no lock on r0 load", lock_act, 0);

    // Same-cycle release and new lock, then replacement.
    drv(1, 1, 7, 1, 32'h7, 0, 1);
    step("R5");
    drv(1, 2, 9, 1, 32'h9, 1, 1);
    step("R6");
    chk("R6", "new lock stands", lock_idx, 9);
    drv(1, 4, 12, 1, 32'hC, 0, 1);
    step("R5");
    chk("R5", "lock replaced", lock_idx, 12);
    drv(0, 0, 0, 0, 32'h0, 1, 1);
    step("R6");

    // Downstream backpressure.
    drv(1, 6, 0, 0, 32'h6666_6666, 0, 0);
    step("R8");
    for (int k = 0; k < 3; k++) begin
      drv(1, 8 + k, 0, 0, 32'h8000_0000 + k, 0, 0);
      step("R9");
      chk("R9", "held data", dn_data, 32'h6666_6666);
      #1 chk("R9", "avail low", avail, 0);
    end
    drv(1, 8, 0, 0, 32'h8000_0000, 0, 1);
    step("R10");
    for (int k = 0; k < 6; k++) begin
      drv(1, k + 1, 0, 0, 32'h5000_0000 + k, 0, 1);
      step("R10");
      chk("R10", "back to back", dn_data, 32'h5000_0000 + k);
    end

    // Lock every nonzero index and probe match, neighbour and r0.
    for (int i = 1; i < 32; i++) begin
      drv(1, 0, i, 1, 32'h2000_0000 + i, 0, 1);
      step("R5");
      drv(1, i, 0, 0, 32'h3000_0000 + i, 0, 1);
      step("R3");
      drv(1, i ^ 1, 0, 0, 32'h4000_0000 + i, 0, 1);
      step((i ^ 1) == 0 ? "R4" : "R2");
      drv(1, 0, 0, 0, 32'h4400_0000 + i, 0, 1);
      step("R4");
      drv(0, 0, 0, 0, 32'h0, 1, 1);
      step("R6");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule